// File: doc/BRIEF.md
# Blanking Pin Driver and Sampler

This block controls a two-way blanking pin at the edge of a video output stage. When the pin is an output, it drives one of two signals. The first is a blanking level that has already passed through the programmable delay line, so it lines up with the blanked span of the analogue outputs. The second is a clock-disable level with no added delay, used to stop and restart the video RAM shift clock. One configuration bit picks the direction of the pin. A second bit picks which of the two output functions is driven.

The clock-disable function differs from plain composite blank in one place. In the first half of the first scan line of an even interlaced field, composite blank is active but clock disable stays low. This keeps the video RAM shift clock running through that half line. When the pin is an input, it is sampled like pixel data on the pixel latch strobe. In grouped mode it is taken once per pixel group, and the group holds 4, 8, 16 or 32 pixels depending on the pixel depth. In per-pixel mode it is taken on every latched pixel.

Each sample leaves the block as a one-cycle valid pulse with the sampled level. The stream has no ready signal and so no back-pressure: the consumer must accept every sample in the cycle it is offered. The sampled level stays on its output until the next sample replaces it.

Top module: `blank_pin_ctrl`

## Requirements
- R1: During and after reset, before any other stimulus, `pin_out`, `ext_valid` and `ext_blank` are all 0.
- R2: `pin_oe` equals `cfg_pin_out` (1 = output, 0 = input) in the same cycle. While `pin_oe` is 0, `pin_out` is 0.
- R3: In output mode with `cfg_clkdis_sel` = 0, `pin_out` equals the value `blank_dly` had one clock earlier.
- R4: In output mode with `cfg_clkdis_sel` = 1, `pin_out` equals the value `blank_raw` had one clock earlier. The exception is when `even_field`, `first_line` and `first_half` were all 1 in that cycle; then `pin_out` is 0.
- R5: In output mode, `pix_strobe` and `pin_in` have no effect: `ext_valid` stays 0 and `ext_blank` keeps its value.
- R6: In input mode with `cfg_pix_mode` = 0 (grouped), the first strobe after entering input mode is sampled. After that, one strobe in every N is sampled, where N = 4, 8, 16 or 32 for `cfg_bpp` = 0, 1, 2 or 3. The strobe count restarts whenever the pin is in output mode.
- R7: In input mode with `cfg_pix_mode` = 1 (per-pixel), every strobe is sampled.
- R8: A sample taken on a strobe in cycle t raises `ext_valid` for exactly cycle t+1, with `ext_blank` equal to `pin_in` at t. `ext_blank` holds that value until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pin_out | input | 1 | 1 = pin is an output, 0 = pin is an input |
| cfg_clkdis_sel | input | 1 | Output function: 0 = delayed blank, 1 = clock disable |
| cfg_pix_mode | input | 1 | Input sampling: 0 = once per group, 1 = every pixel |
| cfg_bpp | input | 2 | Pixel depth code that sets the group length (4 << code) |
| blank_raw | input | 1 | Undelayed composite blank |
| blank_dly | input | 1 | Composite blank after the shared delay line |
| even_field | input | 1 | Current field is the even interlaced field |
| first_line | input | 1 | Current line is the first scan line of the field |
| first_half | input | 1 | Position is within the first half of the line |
| pix_strobe | input | 1 | Pixel latch strobe |
| pin_in | input | 1 | Level read from the pin |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin output enable |
| ext_valid | output | 1 | One-cycle pulse marking a new sample |
| ext_blank | output | 1 | Last sampled external blank level |

## Verification
The hardest case to reach is grouped sampling at the right strobe positions, because a sample only says which strobe was taken through the value it carries. The stimulus drives `pin_in` with a pattern that differs between neighbouring strobes. It runs long strobe trains at each group length and feeds a queue of expected samples. A sample that is shifted, missing or extra shows up as a value mismatch or as a leftover or surplus entry in the queue. The even-field half-line exception is set up by holding composite blank high while the three field-position flags are switched on and off one at a time.

// File: rtl/blank_pin_pkg.sv
package blank_pin_pkg;
  localparam int unsigned BPP_W     = 2;
  localparam int unsigned MIN_GROUP = 4;

  typedef enum logic {
    OUT_FN_BLANK  = 1'b0,
    OUT_FN_CLKDIS = 1'b1
  } out_fn_e;

  // pixel group length for a depth code: 4, 8, 16 or 32
  function automatic int unsigned group_len(input logic [BPP_W-1:0] code);
    return MIN_GROUP << code;
  endfunction
endpackage

// File: rtl/blank_out_path.sv
module blank_out_path
  import blank_pin_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  out_fn_e fn_sel,
  input  logic    blank_raw,
  input  logic    blank_dly,
  input  logic    even_field,
  input  logic    first_line,
  input  logic    first_half,
  output logic    pin_q
);
  logic half_line_hole;
  logic clkdis_lvl;
  logic next_lvl;

  // first half of first line of even field keeps the shift clock running
  assign half_line_hole = even_field & first_line & first_half;
  assign clkdis_lvl     = blank_raw & ~half_line_hole;

  always_comb begin
    unique case (fn_sel)
      OUT_FN_CLKDIS: next_lvl = clkdis_lvl;
      default:       next_lvl = blank_dly;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= next_lvl;
  end

  AST_HOLE_KEEPS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == OUT_FN_CLKDIS && even_field && first_line && first_half) |=> !pin_q); // R4

  AST_CLKDIS_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == OUT_FN_CLKDIS && !(even_field && first_line && first_half)) |=> (pin_q == $past(blank_raw))); // R4

  AST_BLANK_FOLLOWS_DLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == OUT_FN_BLANK) |=> (pin_q == $past(blank_dly))); // R3
endmodule

// File: rtl/blank_in_sampler.sv
module blank_in_sampler
  import blank_pin_pkg::*;
#(
  parameter int unsigned MAX_GROUP = 32,
  localparam int unsigned CNT_W    = $clog2(MAX_GROUP)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             per_pixel,
  input  logic [BPP_W-1:0] bpp,
  input  logic             strobe,
  input  logic             pin_in,
  output logic             smp_valid,
  output logic             smp_data
);
  logic [CNT_W-1:0] cnt;
  logic             at_last;
  logic             take;

  assign at_last = (int'(cnt) + 1 >= int'(group_len(bpp)));
  assign take    = enable & strobe & (per_pixel | (cnt == '0));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      cnt <= '0;
    end else if (strobe && !per_pixel) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= 1'b0;
    end else begin
      smp_valid <= take;
      if (take) smp_data <= pin_in;
    end
  end

  AST_SAMPLE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(strobe && enable)); // R8

  AST_PER_PIXEL_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && per_pixel && strobe) |=> smp_valid); // R7

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_data)); // R8
endmodule

// File: rtl/blank_pin_ctrl.sv
module blank_pin_ctrl
  import blank_pin_pkg::*;
#(
  parameter int unsigned MAX_GROUP = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pin_out,
  input  logic             cfg_clkdis_sel,
  input  logic             cfg_pix_mode,
  input  logic [BPP_W-1:0] cfg_bpp,
  input  logic             blank_raw,
  input  logic             blank_dly,
  input  logic             even_field,
  input  logic             first_line,
  input  logic             first_half,
  input  logic             pix_strobe,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             ext_valid,
  output logic             ext_blank
);
  logic    drv_lvl;
  out_fn_e fn_sel;

  assign fn_sel = out_fn_e'(cfg_clkdis_sel);

  blank_out_path u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .fn_sel     (fn_sel),
    .blank_raw  (blank_raw),
    .blank_dly  (blank_dly),
    .even_field (even_field),
    .first_line (first_line),
    .first_half (first_half),
    .pin_q      (drv_lvl)
  );

  blank_in_sampler #(.MAX_GROUP(MAX_GROUP)) u_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (!cfg_pin_out),
    .per_pixel (cfg_pix_mode),
    .bpp       (cfg_bpp),
    .strobe    (pix_strobe),
    .pin_in    (pin_in),
    .smp_valid (ext_valid),
    .smp_data  (ext_blank)
  );

  assign pin_oe  = cfg_pin_out;
  assign pin_out = cfg_pin_out & drv_lvl;

  AST_QUIET_WHEN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out); // R2

  AST_NO_SAMPLE_AS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_valid |-> $past(!cfg_pin_out)); // R5
endmodule

// File: tb/blank_pin_ctrl_test.sv
module blank_pin_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pin_out = 1'b1, cfg_clkdis_sel = 1'b0, cfg_pix_mode = 1'b0;
  logic [1:0] cfg_bpp = 2'd0;
  logic blank_raw = 0, blank_dly = 0, even_field = 0, first_line = 0, first_half = 0;
  logic pix_strobe = 0, pin_in = 0;
  logic pin_out, pin_oe, ext_valid, ext_blank;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_q[$];
  int grp_cnt = 0;

  always #10 clk = ~clk;

  blank_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_pin_out(cfg_pin_out), .cfg_clkdis_sel(cfg_clkdis_sel),
    .cfg_pix_mode(cfg_pix_mode), .cfg_bpp(cfg_bpp), .blank_raw(blank_raw), .blank_dly(blank_dly),
    .even_field(even_field), .first_line(first_line), .first_half(first_half),
    .pix_strobe(pix_strobe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .ext_valid(ext_valid), .ext_blank(ext_blank)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pop expected samples as the design offers them
  always @(negedge clk) begin
    if (rst_n && ext_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R5/R6 surplus sample", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(ext_blank == e, "R8 sample value", ext_blank, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // driver: one strobe with a level, pushing the expected sample
  task automatic strobe_px(input bit v);
    int glen;
    glen = 4 << cfg_bpp;
    pin_in = v; pix_strobe = 1'b1;
    if (!cfg_pin_out) begin
      if (cfg_pix_mode) exp_q.push_back(v);
      else begin
        if (grp_cnt == 0) exp_q.push_back(v);
        grp_cnt = (grp_cnt + 1 >= glen) ? 0 : grp_cnt + 1;
      end
    end
    tick();
    pix_strobe = 1'b0;
  endtask

  task automatic drain(input string tag);
    tick(); tick();
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic set_input(input bit pm, input logic [1:0] b);
    cfg_pin_out = 1'b1; tick();
    grp_cnt = 0;
    cfg_pix_mode = pm; cfg_bpp = b; cfg_pin_out = 1'b0;
    @(negedge clk);
    check(pin_oe == 1'b0, "R2 oe low in input", pin_oe, 0);
    check(pin_out == 1'b0, "R2 pin_out low in input", pin_out, 0);
    tick();
  endtask

  // drive output-path inputs, let one edge pass, compare at negedge
  task automatic out_step(input bit raw, input bit dly, input bit ev, input bit fl,
                          input bit fh, input bit exp, input string tag);
    blank_raw = raw; blank_dly = dly; even_field = ev; first_line = fl; first_half = fh;
    @(posedge clk); @(negedge clk);
    check(pin_out == exp, tag, pin_out, exp);
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pin_out == 0 && ext_valid == 0 && ext_blank == 0, "R1 reset state",
          {pin_out, ext_valid, ext_blank}, 0);
    #1 rst_n = 1'b1;
    tick();
    @(negedge clk);
    check(pin_out == 0 && ext_valid == 0 && ext_blank == 0, "R1 after reset",
          {pin_out, ext_valid, ext_blank}, 0);
    check(pin_oe == 1'b1, "R2 oe high in output", pin_oe, 1);

    // R3 delayed blank function
    cfg_clkdis_sel = 1'b0;
    out_step(0, 1, 0, 0, 0, 1, "R3 follows blank_dly high");
    out_step(1, 0, 1, 1, 1, 0, "R3 ignores blank_raw");
    out_step(1, 1, 1, 1, 1, 1, "R3 not affected by half-line hole");

    // R4 clock disable function
    cfg_clkdis_sel = 1'b1;
    out_step(1, 0, 0, 0, 0, 1, "R4 follows blank_raw high");
    out_step(0, 1, 0, 0, 0, 0, "R4 ignores blank_dly");
    out_step(1, 1, 1, 1, 1, 0, "R4 even first half-line low");
    out_step(1, 1, 0, 1, 1, 1, "R4 odd field first line high");
    out_step(1, 1, 1, 0, 1, 1, "R4 even other line high");
    out_step(1, 1, 1, 1, 0, 1, "R4 even second half high");

    // R5 strobes ignored as output
    for (int i = 0; i < 6; i++) strobe_px(i[0] ? 1'b1 : 1'b0);
    tick(); @(negedge clk);
    check(ext_valid == 0 && ext_blank == 0, "R5 no sample as output", {ext_valid, ext_blank}, 0);

    // R7 per-pixel mode
    set_input(1'b1, 2'd3);
    for (int i = 0; i < 10; i++) strobe_px((i % 3) == 1);
    drain("R7 per-pixel samples all taken");

    // R8 hold between samples, with strobe gaps
    strobe_px(1'b1);
    for (int i = 0; i < 5; i++) begin pin_in = 1'b0; tick(); end
    @(negedge clk);
    check(ext_blank == 1'b1 && ext_valid == 1'b0, "R8 level held", ext_blank, 1);
    drain("R8 held sample popped");

    // R6 grouped mode at each depth
    for (int b = 0; b < 4; b++) begin
      set_input(1'b0, b[1:0]);
      for (int i = 0; i < 70; i++) begin
        strobe_px(((i / (4 << b)) % 2) == 0 ? (i % (4 << b)) == 0 : (i % (4 << b)) != 0);
        if (i % 7 == 3) tick();
      end
      drain($sformatf("R6 grouped depth code %0d", b));
    end

    // R6 count restarts after a spell in output mode
    set_input(1'b0, 2'd1);
    for (int i = 0; i < 3; i++) strobe_px(1'b0);
    set_input(1'b0, 2'd1);
    strobe_px(1'b1);
    strobe_px(1'b0);
    drain("R6 restart on re-entry");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule